// File: doc/BRIEF.md
# Subroutine Return-Address Stack Pointer

This block keeps the stack pointer of a small command sequencer that supports nested subroutine calls. The pointer is 16 bits wide. Its upper byte is fixed at all ones, so the stack always sits in the top 256-word page of the sequencer's memory, and only the lower byte moves. A call pushes a return address and moves the pointer down. A return moves the pointer up and pops an address. The block drives the memory address for each push or pop. The stack memory itself sits outside the block.

Software can load the lower byte directly through a small register write port. The same port also sets an auto-initialise option. When this option is on, every sequencer start puts the pointer back at the top of the page. When it is off, a start leaves the pointer as it is, so a program that was stopped in the middle of a subroutine can resume with its return addresses intact. A call on a full stack, or a return on an empty stack, is refused: the pointer does not move, and a one-cycle flag is raised instead.

Top module: `ret_stack_ptr`

## Requirements
- R1: `ptr_o[15:8]` always reads 0xFF. A write with `wr_sel_i`=0 loads `wr_data_i[7:0]` into the low byte at the next clock edge and ignores `wr_data_i[15:8]`.
- R2: An accepted call presents the current pointer on `stk_addr_o` in the same cycle. The pointer is one lower after the next edge.
- R3: An accepted return presents pointer+1 on `stk_addr_o` in the same cycle. The pointer becomes that value after the next edge.
- R4: A start with auto-initialise on sets the pointer to 0xFFFF at the next edge.
- R5: A start with auto-initialise off leaves the pointer unchanged.
- R6: Auto-initialise is on after reset. A write with `wr_sel_i`=1 sets it to `wr_data_i[0]`, and this write does not change the pointer.
- R7: Starting from 0xFFFF, 255 calls are accepted. A call made while the low byte is 0x00 leaves the pointer unchanged and raises `overflow_o` for exactly one cycle after the edge.
- R8: A return made while the pointer is 0xFFFF leaves it unchanged and raises `underflow_o` for exactly one cycle after the edge.
- R9: When several actions occur in the same cycle, the priority is start > pointer write > call > return. Only the highest-priority action takes effect.
- R10: After reset the pointer is 0xFFFF and both flags are 0. On idle cycles `stk_addr_o` equals the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sequencer start pulse |
| call_i | input | 1 | Subroutine call (push) |
| ret_i | input | 1 | Subroutine return (pop) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: pointer low byte, 1: auto-initialise bit |
| wr_data_i | input | 16 | Register write data |
| ptr_o | output | 16 | Current stack pointer |
| stk_addr_o | output | 16 | Push/pop memory address |
| overflow_o | output | 1 | Refused-call pulse |
| underflow_o | output | 1 | Refused-return pulse |

## Verification
Calls are run as a chain of consecutive pushes followed by pops. This separates the push-address rule (the current pointer) from the pop-address rule (pointer plus one), and it checks that the pointer moves in the right direction. A full descent of 256 calls from the top of the page shows the exact capacity limit and the single-cycle width of the overflow flag. Starts are issued with auto-initialise both on and off, after a pointer load that uses a nonzero upper byte. This tells resume behaviour apart from reinitialisation, and it shows that the upper byte is ignored. Simultaneous start, write, call and return inputs are applied to settle the priority order.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_INIT,
        OP_HOLD,
        OP_LOAD,
        OP_PUSH,
        OP_POP,
        OP_OVF,
        OP_UNF
    } sp_op_e;

endpackage

// File: rtl/rsp_cfg_reg.sv
module rsp_cfg_reg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_en_i,
    input  logic wr_sel_i,
    input  logic wr_bit_i,
    output logic auto_init_o
);
    logic auto_d, auto_q;

    always_comb begin
        auto_d = auto_q;
        if (wr_en_i && wr_sel_i) begin
            auto_d = wr_bit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            auto_q <= 1'b1;
        end else begin
            auto_q <= auto_d;
        end
    end

    assign auto_init_o = auto_q;

    // R6: a config write is reflected on the next cycle
    a_r6_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i) |=> (auto_q == $past(wr_bit_i)));

endmodule

// File: rtl/rsp_op_decode.sv
module rsp_op_decode
    import ret_stack_pkg::*;
(
    input  logic   start_i,
    input  logic   auto_init_i,
    input  logic   wr_en_i,
    input  logic   wr_sel_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   at_floor_i,
    input  logic   at_top_i,
    output sp_op_e op_o
);
    // Priority: start, pointer write, call, return
    always_comb begin
        op_o = OP_IDLE;
        if (start_i) begin
            op_o = auto_init_i ? OP_INIT : OP_HOLD;
        end else if (wr_en_i && !wr_sel_i) begin
            op_o = OP_LOAD;
        end else if (call_i) begin
            op_o = at_floor_i ? OP_OVF : OP_PUSH;
        end else if (ret_i) begin
            op_o = at_top_i ? OP_UNF : OP_POP;
        end
    end

endmodule

// File: rtl/rsp_ptr_core.sv
module rsp_ptr_core
    import ret_stack_pkg::*;
#(
    parameter int LOW_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  sp_op_e           op_i,
    input  logic [LOW_W-1:0] load_i,
    output logic [LOW_W-1:0] low_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam logic [LOW_W-1:0] LOW_TOP = {LOW_W{1'b1}};
    localparam logic [LOW_W-1:0] LOW_ONE = {{(LOW_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [LOW_W-1:0] low;
        logic             ovf;
        logic             unf;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        case (op_i)
            OP_INIT: st_d.low = LOW_TOP;
            OP_LOAD: st_d.low = load_i;
            OP_PUSH: st_d.low = st_q.low - LOW_ONE;
            OP_POP:  st_d.low = st_q.low + LOW_ONE;
            OP_OVF:  st_d.ovf = 1'b1;
            OP_UNF:  st_d.unf = 1'b1;
            default: st_d = st_q;
        endcase
        if (op_i != OP_OVF) st_d.ovf = 1'b0;
        if (op_i != OP_UNF) st_d.unf = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.low <= LOW_TOP;
            st_q.ovf <= 1'b0;
            st_q.unf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_o = st_q.low;
    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;

    // R4: initialisation lands at the top of the page
    a_r4_init_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_INIT) |=> (st_q.low == LOW_TOP));
    // R5: a start without auto-initialise keeps the pointer
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_HOLD) |=> $stable(st_q.low));
    // R7: a refused call freezes the pointer and flags it
    a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_OVF) |=> (st_q.ovf && $stable(st_q.low)));
    // R8: a refused return freezes the pointer and flags it
    a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_UNF) |=> (st_q.unf && $stable(st_q.low)));
    // R7, R8: the flags never both pulse together
    a_r7_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.ovf && st_q.unf));
    // R1: a pointer load takes the written byte
    a_r1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_LOAD) |=> (st_q.low == $past(load_i)));

endmodule

// File: rtl/rsp_addr_gen.sv
module rsp_addr_gen
    import ret_stack_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int LOW_W = 8
) (
    input  sp_op_e           op_i,
    input  logic [LOW_W-1:0] low_i,
    output logic [PTR_W-1:0] addr_o
);
    localparam int HIGH_W = PTR_W - LOW_W;
    localparam logic [HIGH_W-1:0] PAGE = {HIGH_W{1'b1}};
    localparam logic [LOW_W-1:0] LOW_ONE = {{(LOW_W-1){1'b0}}, 1'b1};

    logic [LOW_W-1:0] low_sel;

    // Push writes at the current slot; pop pre-increments and reads
    always_comb begin
        low_sel = low_i;
        if (op_i == OP_POP) begin
            low_sel = low_i + LOW_ONE;
        end
    end

    assign addr_o = {PAGE, low_sel};

endmodule

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
    import ret_stack_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [PTR_W-1:0] wr_data_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] stk_addr_o,
    output logic             overflow_o,
    output logic             underflow_o
);
    localparam int HIGH_W = PTR_W - LOW_W;
    localparam logic [HIGH_W-1:0] PAGE = {HIGH_W{1'b1}};

    sp_op_e           op;
    logic             auto_init;
    logic [LOW_W-1:0] low;
    logic             at_floor, at_top;

    assign at_floor = ~|low;
    assign at_top   = &low;

    rsp_cfg_reg u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_bit_i    (wr_data_i[0]),
        .auto_init_o (auto_init)
    );

    rsp_op_decode u_dec (
        .start_i     (start_i),
        .auto_init_i (auto_init),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .at_floor_i  (at_floor),
        .at_top_i    (at_top),
        .op_o        (op)
    );

    rsp_ptr_core #(.LOW_W(LOW_W)) u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (op),
        .load_i (wr_data_i[LOW_W-1:0]),
        .low_o  (low),
        .ovf_o  (overflow_o),
        .unf_o  (underflow_o)
    );

    rsp_addr_gen #(.PTR_W(PTR_W), .LOW_W(LOW_W)) u_addr (
        .op_i   (op),
        .low_i  (low),
        .addr_o (stk_addr_o)
    );

    assign ptr_o = {PAGE, low};

    // R2: after a push, the pointer sits one below the pushed slot
    a_r2_push_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_PUSH) |=> (ptr_o == $past(stk_addr_o) - 1'b1));
    // R3: after a pop, the pointer equals the address that was read
    a_r3_pop_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_POP) |=> (ptr_o == $past(stk_addr_o)));
    // R9: a start blocks any concurrent call
    a_r9_start_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !auto_init && call_i) |=> $stable(ptr_o));

endmodule

// File: tb/ret_stack_ptr_tb.sv
module ret_stack_ptr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, call = 1'b0, ret = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ptr, addr;
    logic        ovf, unf;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ret_stack_ptr dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .call_i(call), .ret_i(ret),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .ptr_o(ptr), .stk_addr_o(addr), .overflow_o(ovf), .underflow_o(unf)
    );

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check address before the edge,
    // check pointer and flags at the following negedge.
    task automatic step(string tag, logic s, logic c, logic r, logic we, logic ws,
                        logic [15:0] d, logic [15:0] e_addr, logic [15:0] e_ptr,
                        logic e_ovf, logic e_unf);
        start = s; call = c; ret = r; wr_en = we; wr_sel = ws; wr_data = d;
        #1;
        check16({tag, " addr"}, addr, e_addr);
        @(posedge clk);
        @(negedge clk);
        start = 0; call = 0; ret = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
        check16({tag, " ptr"}, ptr, e_ptr);
        check1({tag, " ovf"}, ovf, e_ovf);
        check1({tag, " unf"}, unf, e_unf);
    endtask

    task automatic t_reset();
        check16("R10 reset ptr", ptr, 16'hFFFF);
        check1("R10 reset ovf", ovf, 1'b0);
        check1("R10 reset unf", unf, 1'b0);
        check16("R10 idle addr", addr, 16'hFFFF);
    endtask

    task automatic t_push_pop();
        step("R2 call1", 0,1,0,0,0,0, 16'hFFFF, 16'hFFFE, 0,0);
        step("R2 call2", 0,1,0,0,0,0, 16'hFFFE, 16'hFFFD, 0,0);
        step("R2 call3", 0,1,0,0,0,0, 16'hFFFD, 16'hFFFC, 0,0);
        step("R3 ret1",  0,0,1,0,0,0, 16'hFFFD, 16'hFFFD, 0,0);
        step("R3 ret2",  0,0,1,0,0,0, 16'hFFFE, 16'hFFFE, 0,0);
    endtask

    task automatic t_write();
        step("R1 load", 0,0,0,1,0,16'hAB12, 16'hFFFE, 16'hFF12, 0,0);
        check16("R1 upper byte", {ptr[15:8], 8'h00}, 16'hFF00);
    endtask

    task automatic t_start();
        step("R4 start auto", 1,0,0,0,0,0, 16'hFF12, 16'hFFFF, 0,0);
        step("R6 cfg off", 0,0,0,1,1,16'h0000, 16'hFFFF, 16'hFFFF, 0,0);
        step("R1 load 40", 0,0,0,1,0,16'h0040, 16'hFFFF, 16'hFF40, 0,0);
        step("R5 start hold", 1,0,0,0,0,0, 16'hFF40, 16'hFF40, 0,0);
        step("R5 resume call", 0,1,0,0,0,0, 16'hFF40, 16'hFF3F, 0,0);
        step("R6 cfg on", 0,0,0,1,1,16'h0001, 16'hFF3F, 16'hFF3F, 0,0);
        step("R6 start auto", 1,0,0,0,0,0, 16'hFF3F, 16'hFFFF, 0,0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 255; i++) begin
            step("R7 fill", 0,1,0,0,0,0, 16'hFFFF - 16'(i), 16'hFFFE - 16'(i), 0,0);
        end
        step("R7 overflow", 0,1,0,0,0,0, 16'hFF00, 16'hFF00, 1,0);
        step("R7 flag clears", 0,0,0,0,0,0, 16'hFF00, 16'hFF00, 0,0);
        step("R3 pop from floor", 0,0,1,0,0,0, 16'hFF01, 16'hFF01, 0,0);
    endtask

    task automatic t_underflow();
        step("R4 restart", 1,0,0,0,0,0, 16'hFF01, 16'hFFFF, 0,0);
        step("R8 underflow", 0,0,1,0,0,0, 16'hFFFF, 16'hFFFF, 0,1);
        step("R8 flag clears", 0,0,0,0,0,0, 16'hFFFF, 16'hFFFF, 0,0);
    endtask

    task automatic t_priority();
        step("R9 call over ret", 0,1,1,0,0,0, 16'hFFFF, 16'hFFFE, 0,0);
        step("R9 write over call", 0,1,0,1,0,16'h0080, 16'hFFFE, 16'hFF80, 0,0);
        step("R9 start over write", 1,0,0,1,0,16'h0011, 16'hFF80, 16'hFFFF, 0,0);
        step("R9 start over call", 1,1,0,0,0,0, 16'hFFFF, 16'hFFFF, 0,0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_write();
        t_start();
        t_overflow();
        t_underflow();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule